// File: doc/BRIEF.md
# I/O Page Table Walker

This block turns a device DMA address into a system address by walking a tree of 64-bit translation entries held in memory. A request carries the DMA address, a write flag and the partition number of the device. The block picks one of two windows from the address. It reads that window's 64-bit descriptor from an external descriptor table through a combinational lookup port. Then it either maps the address straight through (bypass) or walks from one to five table levels. Each level costs one 64-bit memory read.

Walks run strictly one at a time. While a walk is in flight `busy` stays high and new requests are not taken. Each walk ends with a one-cycle `out_valid` pulse that carries either a translated address and page mask, or a fault flag with a three-bit cause. The descriptor is split into these fields:

- bits 58:56: extra-level count, where 0 means a single level.
- bits 55:52: table-size field.
- bit 51: bypass permit.
- bits 47:12: table base.
- bits 4:0: page-size field.

All other descriptor bits are ignored.

The controller has five states:

- IDLE waits for a request and moves to LOOKUP when `req_valid` is seen.
- LOOKUP checks the address and descriptor. It moves to DONE on a fault or a bypass result, and to ISSUE when a walk starts.
- ISSUE sends one read and always moves to WAIT.
- WAIT holds until a response arrives. It moves back to ISSUE for a good non-final entry, and to DONE on a final entry, a memory error or a bad indirect entry.
- DONE presents the result for one cycle and returns to IDLE.

Top module: `iopt_walker`

## Requirements
- R1: While reset is asserted and after it is released, `busy`, `mem_req_valid` and `out_valid` are low until a request arrives.
- R2: A request whose address bits 63:60 are not all zero ends with fault cause 1 and issues no memory read.
- R3: When `msi32_en` is high, an address with bits 63:16 equal to 0xFFFF (the 64 KiB region starting at 0xFFFF0000) faults with cause 2 and issues no read. When `msi32_en` is low, the same address is walked normally.
- R4: The descriptor used is entry `desc_index = partition*2 + address bit 59`.
- R5: Bypass mode applies when the page-size field is 0.
  - If descriptor bit 51 is set, the result is the address ANDed with 0x0003_FFFF_FFFF_F000, with page mask 0xFFF and no memory read.
  - If bit 51 is clear, the walk faults with cause 3.
- R6: In translated mode, an extra-level count above 4 faults with cause 4 and issues no read. A count of exactly 4 is walked.
- R7: The walk uses these quantities:
  - Bits per level = table-size field + 8.
  - Page shift = page-size field + 11.
  - Starting shift = bits per level × extra-level count + page shift.
  - Each read address = base OR (((address >> shift) AND (2^bits − 1)) << 3).
  - After each non-final level, the shift drops by the bits per level.
  - The walk makes exactly count+1 reads unless it faults earlier.
- R8: Entries are big-endian in memory. Byte 0 of `mem_rsp_data` (bits 7:0) is the byte at the lowest address and is the most significant byte of the entry.
- R9: A non-final entry with bits 1:0 both zero faults with cause 6. Otherwise the next base is that entry with bits 11:0 cleared.
- R10: In the final entry, bit 0 grants read and bit 1 grants write. An access without its bit faults with cause 7.
- R11: A successful walk outputs address = final entry AND NOT(2^pageshift − 1), with page mask 2^pageshift − 1.
- R12: A memory response with `mem_rsp_err` set ends the walk at once with fault cause 5.
- R13: Walks are serialised, as follows:
  - `busy` is high from the accepting edge until the result.
  - `req_valid` during a walk is ignored.
  - `out_valid` is a single-cycle pulse after which the block is idle.
  - `out_fault` is high exactly when `out_cause` is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start a walk (taken only when idle) |
| req_addr | input | 64 | DMA address |
| req_write | input | 1 | 1 = write access, 0 = read |
| req_part | input | PART_W | Partition number |
| msi32_en | input | 1 | 32-bit message window enable |
| busy | output | 1 | Walk in flight |
| desc_index | output | PART_W+1 | Descriptor table index |
| desc_word | input | 64 | Descriptor at `desc_index`, combinational |
| mem_req_valid | output | 1 | One-cycle memory read request |
| mem_req_addr | output | 64 | Entry address |
| mem_rsp_valid | input | 1 | Memory response strobe |
| mem_rsp_data | input | 64 | Entry bytes, lowest address in bits 7:0 |
| mem_rsp_err | input | 1 | Memory read error |
| out_valid | output | 1 | Result pulse |
| out_fault | output | 1 | Walk faulted |
| out_cause | output | 3 | 0 none, 1 region, 2 message window, 3 bypass denied, 4 depth, 5 memory error, 6 indirect, 7 permission |
| out_paddr | output | 64 | Translated address |
| out_pmask | output | 64 | Page offset mask |

## Verification
The bench tries several kinds of stimulus, and each one tells apart a different part of the design:

- A two-level walk with three neighbouring addresses shares the top entry but reaches different leaves. Read, write-denied and write-granted leaves then separate the two permission bits.
- A single-level walk in the second window of the same partition, with 32 KiB pages, shows that bit 59 picks a different descriptor and that the page shift comes from the descriptor.
- A four-level walk with 8-bit indices checks shift stepping across every level.
- Bad-region, message-window (enable on and off), bypass (permit on and off), depth-4/depth-5, zero-indirect and memory-error cases each stop the walk at a distinct point. Matching the read count tells these stop points apart.
- Requests raised mid-walk must leave the result and the read count unchanged.

// File: rtl/iopt_pkg.sv
package iopt_pkg;

    typedef enum logic [2:0] {
        FLT_NONE     = 3'd0,
        FLT_REGION   = 3'd1,
        FLT_MSI32    = 3'd2,
        FLT_NOBYP    = 3'd3,
        FLT_DEPTH    = 3'd4,
        FLT_MEMERR   = 3'd5,
        FLT_INDIRECT = 3'd6,
        FLT_PERM     = 3'd7
    } fault_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_LOOKUP, ST_ISSUE, ST_WAIT, ST_DONE
    } walk_st_e;

    typedef struct packed {
        logic [2:0]  depth;
        logic [3:0]  tbl_sz;
        logic        byp_ok;
        logic [35:0] base_pg;
        logic [4:0]  pg_sz;
    } wdesc_t;

    function automatic wdesc_t split_desc(input logic [63:0] w);
        wdesc_t d;
        d.depth   = w[58:56];
        d.tbl_sz  = w[55:52];
        d.byp_ok  = w[51];
        d.base_pg = w[47:12];
        d.pg_sz   = w[4:0];
        return d;
    endfunction

    // memory lane 0 holds the most significant byte of the entry
    function automatic logic [63:0] lanes_to_word(input logic [63:0] lanes);
        logic [63:0] w;
        for (int i = 0; i < 8; i++) begin
            w[8*i +: 8] = lanes[8*(7-i) +: 8];
        end
        return w;
    endfunction

endpackage

// File: rtl/iopt_window_decode.sv
module iopt_window_decode
    import iopt_pkg::*;
#(
    parameter int LVL_MAX = 4
) (
    input  logic [63:0] addr,
    input  logic        msi32_en,
    input  logic [63:0] desc_word,
    output fault_e      cause,
    output logic        bypass,
    output logic [63:0] byp_paddr,
    output logic [63:0] walk_base,
    output logic [7:0]  walk_shift,
    output logic [4:0]  walk_bits,
    output logic [2:0]  walk_depth,
    output logic [5:0]  walk_pshift
);
    localparam logic [63:0] BYP_KEEP = 64'h0003_FFFF_FFFF_F000;

    wdesc_t d;
    logic   unused_desc;

    assign d           = split_desc(desc_word);
    assign unused_desc = ^{desc_word[63:59], desc_word[50:48], desc_word[11:5]};

    assign walk_bits   = {1'b0, d.tbl_sz} + 5'd8;
    assign walk_pshift = {1'b0, d.pg_sz} + 6'd11;
    assign walk_depth  = d.depth;
    assign walk_base   = {16'h0, d.base_pg, 12'h000};
    assign walk_shift  = ({3'b0, walk_bits} * {5'b0, d.depth}) + {2'b0, walk_pshift};
    assign byp_paddr   = addr & BYP_KEEP;

    always_comb begin
        cause  = FLT_NONE;
        bypass = 1'b0;
        if (addr[63:60] != 4'h0) begin
            cause = FLT_REGION;
        end else if (msi32_en && (addr[63:16] == 48'h0000_0000_FFFF)) begin
            cause = FLT_MSI32;
        end else if (d.pg_sz == 5'd0) begin
            if (d.byp_ok) bypass = 1'b1;
            else          cause  = FLT_NOBYP;
        end else if (int'(d.depth) > LVL_MAX) begin
            cause = FLT_DEPTH;
        end
    end
endmodule

// File: rtl/iopt_entry_calc.sv
module iopt_entry_calc (
    input  logic [63:0] base,
    input  logic [63:0] addr,
    input  logic [7:0]  shift,
    input  logic [4:0]  bits,
    input  logic [5:0]  pshift,
    output logic [63:0] ent_addr,
    output logic [63:0] page_lo
);
    logic [63:0] idx_mask;

    assign idx_mask = (64'd1 << bits) - 64'd1;
    assign ent_addr = base | (((addr >> shift) & idx_mask) << 3);
    assign page_lo  = (64'd1 << pshift) - 64'd1;
endmodule

// File: rtl/iopt_walker.sv
module iopt_walker
    import iopt_pkg::*;
#(
    parameter int PART_W  = 6,
    parameter int LVL_MAX = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [63:0]       req_addr,
    input  logic              req_write,
    input  logic [PART_W-1:0] req_part,
    input  logic              msi32_en,
    output logic              busy,
    output logic [PART_W:0]   desc_index,
    input  logic [63:0]       desc_word,
    output logic              mem_req_valid,
    output logic [63:0]       mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [63:0]       mem_rsp_data,
    input  logic              mem_rsp_err,
    output logic              out_valid,
    output logic              out_fault,
    output logic [2:0]        out_cause,
    output logic [63:0]       out_paddr,
    output logic [63:0]       out_pmask
);
    localparam int IDX_W = PART_W + 1;

    walk_st_e          st, st_nx;
    logic [63:0]       r_addr, r_base;
    logic              r_wr;
    logic [PART_W-1:0] r_part;
    logic [7:0]        r_shift;
    logic [4:0]        r_bits;
    logic [2:0]        r_left;
    logic [5:0]        r_pshift;
    logic              res_fault;
    fault_e            res_cause;
    logic [63:0]       res_paddr, res_pmask;

    fault_e      dec_cause;
    logic        dec_byp;
    logic [63:0] dec_byp_paddr, dec_base;
    logic [7:0]  dec_shift;
    logic [4:0]  dec_bits;
    logic [2:0]  dec_depth;
    logic [5:0]  dec_pshift;
    logic [63:0] ent_addr, page_lo, ent;
    logic        ent_perm;

    iopt_window_decode #(.LVL_MAX(LVL_MAX)) u_dec (
        .addr(r_addr), .msi32_en(msi32_en), .desc_word(desc_word),
        .cause(dec_cause), .bypass(dec_byp), .byp_paddr(dec_byp_paddr),
        .walk_base(dec_base), .walk_shift(dec_shift), .walk_bits(dec_bits),
        .walk_depth(dec_depth), .walk_pshift(dec_pshift)
    );

    iopt_entry_calc u_calc (
        .base(r_base), .addr(r_addr), .shift(r_shift), .bits(r_bits),
        .pshift(r_pshift), .ent_addr(ent_addr), .page_lo(page_lo)
    );

    assign desc_index   = IDX_W'({r_part, r_addr[59]});
    assign mem_req_addr = ent_addr;
    assign ent          = lanes_to_word(mem_rsp_data);
    assign ent_perm     = r_wr ? ent[1] : ent[0];

    // next-state logic
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:   if (req_valid) st_nx = ST_LOOKUP;
            ST_LOOKUP: st_nx = (dec_cause != FLT_NONE || dec_byp) ? ST_DONE : ST_ISSUE;
            ST_ISSUE:  st_nx = ST_WAIT;
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    if (!mem_rsp_err && r_left != 3'd0 && ent[1:0] != 2'b00)
                        st_nx = ST_ISSUE;
                    else
                        st_nx = ST_DONE;
                end
            end
            ST_DONE:   st_nx = ST_IDLE;
            default:   st_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // outputs
    always_comb begin
        busy          = (st != ST_IDLE);
        mem_req_valid = (st == ST_ISSUE);
        out_valid     = (st == ST_DONE);
        out_fault     = res_fault;
        out_cause     = res_cause;
        out_paddr     = res_paddr;
        out_pmask     = res_pmask;
    end

    // walk datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_addr <= '0; r_wr <= 1'b0; r_part <= '0; r_base <= '0;
            r_shift <= '0; r_bits <= '0; r_left <= '0; r_pshift <= '0;
            res_fault <= 1'b0; res_cause <= FLT_NONE;
            res_paddr <= '0; res_pmask <= '0;
        end else begin
            unique case (st)
                ST_IDLE: if (req_valid) begin
                    r_addr <= req_addr;
                    r_wr   <= req_write;
                    r_part <= req_part;
                end
                ST_LOOKUP: begin
                    res_fault <= (dec_cause != FLT_NONE);
                    res_cause <= dec_cause;
                    res_paddr <= '0;
                    res_pmask <= '0;
                    if (dec_cause == FLT_NONE && dec_byp) begin
                        res_paddr <= dec_byp_paddr;
                        res_pmask <= 64'hFFF;
                    end
                    r_base   <= dec_base;
                    r_shift  <= dec_shift;
                    r_bits   <= dec_bits;
                    r_left   <= dec_depth;
                    r_pshift <= dec_pshift;
                end
                ST_WAIT: if (mem_rsp_valid) begin
                    if (mem_rsp_err) begin
                        res_fault <= 1'b1;
                        res_cause <= FLT_MEMERR;
                    end else if (r_left != 3'd0) begin
                        if (ent[1:0] == 2'b00) begin
                            res_fault <= 1'b1;
                            res_cause <= FLT_INDIRECT;
                        end
                        r_base  <= {ent[63:12], 12'h000};
                        r_shift <= r_shift - {3'b0, r_bits};
                        r_left  <= r_left - 3'd1;
                    end else if (!ent_perm) begin
                        res_fault <= 1'b1;
                        res_cause <= FLT_PERM;
                    end else begin
                        res_fault <= 1'b0;
                        res_cause <= FLT_NONE;
                        res_paddr <= ent & ~page_lo;
                        res_pmask <= page_lo;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/iopt_walker_chk.sv
module iopt_walker_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        busy,
    input logic        mem_req_valid,
    input logic [63:0] mem_req_addr,
    input logic        out_valid,
    input logic        out_fault,
    input logic [2:0]  out_cause,
    input logic [63:0] out_paddr,
    input logic [63:0] out_pmask
);
    // R13
    read_in_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> busy);

    // R13
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> busy);

    // R13
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> (!out_valid && !busy));

    // R13
    no_read_at_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req_valid && out_valid));

    // R7
    entry_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_addr[2:0] == 3'b000));

    // R11
    page_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_fault) |-> (((out_paddr & out_pmask) == 64'd0) &&
                                       $onehot0(out_pmask + 64'd1)));

    // R13
    cause_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_fault == (out_cause != 3'd0)));
endmodule

bind iopt_walker iopt_walker_chk u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .busy(busy),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .out_valid(out_valid), .out_fault(out_fault), .out_cause(out_cause),
    .out_paddr(out_paddr), .out_pmask(out_pmask)
);

// File: tb/iopt_walker_tb.sv
`timescale 1ns/1ps
module iopt_walker_tb;

    typedef struct {
        logic        fault;
        logic [2:0]  cause;
        logic [63:0] paddr;
        logic [63:0] pmask;
        int          reads;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [63:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [5:0]  req_part = '0;
    logic        msi32_en = 1'b0;
    logic        busy;
    logic [6:0]  desc_index;
    logic [63:0] desc_word;
    logic        mem_req_valid;
    logic [63:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        mem_rsp_err = 1'b0;
    logic        out_valid, out_fault;
    logic [2:0]  out_cause;
    logic [63:0] out_paddr, out_pmask;

    logic [63:0] desc_tbl [0:127];
    logic [63:0] mem_m [logic [63:0]];
    bit          err_m [logic [63:0]];
    exp_t        exp_q [$];
    int          n_chk = 0, n_bad = 0, rd_cnt = 0;

    always #4 clk = ~clk;

    assign desc_word = desc_tbl[desc_index];

    iopt_walker u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .req_part(req_part), .msi32_en(msi32_en),
        .busy(busy), .desc_index(desc_index), .desc_word(desc_word),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .mem_rsp_err(mem_rsp_err), .out_valid(out_valid), .out_fault(out_fault),
        .out_cause(out_cause), .out_paddr(out_paddr), .out_pmask(out_pmask)
    );

    function automatic logic [63:0] rdmem(input logic [63:0] a);
        return mem_m.exists(a) ? mem_m[a] : 64'd0;
    endfunction

    function automatic logic [63:0] to_lanes(input logic [63:0] v);
        logic [63:0] r;
        for (int b = 0; b < 8; b++) r[8*b +: 8] = v[63-8*b -: 8];
        return r;
    endfunction

    function automatic logic [63:0] mkdesc(input logic [63:0] base, input int lev,
                                           input int tsz, input int ps, input bit byp);
        return {5'b0, 3'(lev), 4'(tsz), byp, 3'b0, base[47:12], 7'b0, 5'(ps)};
    endfunction

    function automatic logic [63:0] eaddr(input logic [63:0] base, input logic [63:0] a,
                                          input int sh, input int bits);
        logic [63:0] idx;
        idx = (sh >= 64) ? 64'd0 : ((a >> sh) & ((64'd1 << bits) - 64'd1));
        return base | (idx << 3);
    endfunction

    function automatic exp_t ref_walk(input logic [63:0] a, input bit wr,
                                      input int part, input bit msi);
        exp_t e;
        logic [63:0] d, base, ent, ea;
        int lev, bits, ps, sh, tsh;
        e.fault = 1'b1; e.cause = 3'd0; e.paddr = '0; e.pmask = '0; e.reads = 0;
        d = desc_tbl[part*2 + int'(a[59])];
        if (a[63:60] != 4'h0) begin e.cause = 3'd1; return e; end
        if (msi && a[63:16] == 48'h0000_0000_FFFF) begin e.cause = 3'd2; return e; end
        ps = int'(d[4:0]); lev = int'(d[58:56]); bits = int'(d[55:52]) + 8;
        base = {16'h0, d[47:12], 12'h0};
        if (ps == 0) begin
            if (!d[51]) e.cause = 3'd3;
            else begin
                e.fault = 1'b0; e.paddr = a & 64'h0003_FFFF_FFFF_F000; e.pmask = 64'hFFF;
            end
            return e;
        end
        if (lev > 4) begin e.cause = 3'd4; return e; end
        tsh = ps + 11;
        sh  = bits * lev + tsh;
        for (int l = lev; l >= 0; l--) begin
            ea = eaddr(base, a, sh, bits);
            e.reads++;
            if (err_m.exists(ea)) begin e.cause = 3'd5; return e; end
            ent = rdmem(ea);
            if (l > 0) begin
                if (ent[1:0] == 2'b00) begin e.cause = 3'd6; return e; end
                base = {ent[63:12], 12'h0};
                sh   = sh - bits;
            end else begin
                if (wr ? !ent[1] : !ent[0]) begin e.cause = 3'd7; return e; end
                e.fault = 1'b0;
                e.pmask = (64'd1 << tsh) - 64'd1;
                e.paddr = ent & ~e.pmask;
            end
        end
        return e;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic walk(input logic [63:0] a, input bit wr, input int part,
                        input bit msi, input string tag, input bit noise);
        exp_t e;
        e = ref_walk(a, wr, part, msi);
        e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk);
        req_addr = a; req_write = wr; req_part = 6'(part); msi32_en = msi;
        req_valid = 1'b1; rd_cnt = 0;
        @(negedge clk);
        req_valid = 1'b0;
        if (noise) begin
            req_valid = 1'b1;
            req_addr  = 64'hF000_0000_0000_0000;
            req_write = ~wr;
            repeat (2) @(negedge clk);
            req_valid = 1'b0;
        end
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    // memory responder: one cycle of latency after the request is seen
    initial begin
        logic [63:0] pa;
        bit pend;
        pend = 1'b0; pa = '0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            mem_rsp_err   = 1'b0;
            if (pend) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_err   = err_m.exists(pa);
                mem_rsp_data  = to_lanes(rdmem(pa));
                pend = 1'b0;
            end else if (rst_n && mem_req_valid) begin
                pa = mem_req_addr;
                pend = 1'b1;
                rd_cnt++;
            end
        end
    end

    // scoreboard monitor
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            if (rst_n && out_valid) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R13 unexpected result", {61'b0, out_cause}, 64'd0);
                end else begin
                    e = exp_q.pop_front();
                    chk({out_fault, out_cause} == {e.fault, e.cause},
                        {e.tag, " fault/cause"}, {60'b0, out_fault, out_cause},
                        {60'b0, e.fault, e.cause});
                    chk(out_paddr == e.paddr, {e.tag, " paddr"}, out_paddr, e.paddr);
                    chk(out_pmask == e.pmask, {e.tag, " pmask"}, out_pmask, e.pmask);
                    chk(rd_cnt == e.reads, {e.tag, " reads"}, 64'(rd_cnt), 64'(e.reads));
                end
            end
        end
    end

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [63:0] a_rd, a_wd, a_wg, b_addr, c_addr, d_addr, e_addr;
        for (int i = 0; i < 128; i++) desc_tbl[i] = '0;

        a_rd   = 64'h0000_0000_1234_5678;
        a_wd   = 64'h0000_0000_1234_6678;
        a_wg   = 64'h0000_0000_1234_7678;
        b_addr = 64'h0800_0000_0040_8000;
        c_addr = 64'h0000_0012_3456_7000;
        d_addr = 64'h0000_0000_5000_0000;
        e_addr = 64'h0000_0000_0800_0000;

        // partition 3: window 0 two levels, 9-bit index, 4 KiB pages
        desc_tbl[6]  = mkdesc(64'h10000, 1, 1, 1, 1'b0);
        // partition 3: window 1 one level, 10-bit index, 32 KiB pages
        desc_tbl[7]  = mkdesc(64'h30000, 0, 2, 4, 1'b0);
        desc_tbl[10] = mkdesc(64'h0, 0, 0, 0, 1'b1);
        desc_tbl[11] = mkdesc(64'h0, 0, 0, 0, 1'b0);
        desc_tbl[12] = mkdesc(64'h10000, 5, 1, 1, 1'b0);
        desc_tbl[14] = mkdesc(64'h40000, 3, 0, 1, 1'b0);
        desc_tbl[16] = mkdesc(64'hA0000, 4, 0, 1, 1'b0);

        mem_m[eaddr(64'h10000, a_rd, 21, 9)] = 64'h20003;
        mem_m[eaddr(64'h20000, a_rd, 12, 9)] = 64'hABCD_E001;
        mem_m[eaddr(64'h20000, a_wd, 12, 9)] = 64'hBBBB_0001;
        mem_m[eaddr(64'h20000, a_wg, 12, 9)] = 64'hCCCC_1003;
        mem_m[eaddr(64'h30000, b_addr, 15, 10)] = 64'h0000_0012_3456_8003;
        mem_m[eaddr(64'h10000, d_addr, 21, 9)] = 64'h80001;
        err_m[eaddr(64'h80000, d_addr, 12, 9)] = 1'b1;
        mem_m[eaddr(64'h10000, e_addr, 21, 9)] = 64'h90000;
        for (int l = 0; l < 4; l++) begin
            mem_m[eaddr(64'h40000 + 64'(l) * 64'h10000, c_addr, 36 - 8*l, 8)] =
                (l < 3) ? (64'h50000 + 64'(l) * 64'h10000) | 64'h2 : 64'hDEAD_B001;
        end

        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R1 busy in reset", 64'(busy), 64'd0);
        chk(out_valid == 1'b0, "R1 out_valid in reset", 64'(out_valid), 64'd0);
        chk(mem_req_valid == 1'b0, "R1 mem_req_valid in reset", 64'(mem_req_valid), 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(busy == 1'b0 && mem_req_valid == 1'b0 && out_valid == 1'b0,
            "R1 idle after reset", {61'b0, busy, mem_req_valid, out_valid}, 64'd0);

        walk(a_rd, 1'b0, 3, 1'b0, "R7/R8/R11 two-level read", 1'b0);
        walk(a_wd, 1'b1, 3, 1'b0, "R10 write without grant", 1'b0);
        walk(a_wg, 1'b1, 3, 1'b0, "R10/R11 write granted", 1'b0);
        walk(b_addr, 1'b0, 3, 1'b0, "R4/R11 window one 32K page", 1'b0);
        walk(c_addr, 1'b0, 7, 1'b0, "R7/R9 four levels", 1'b0);
        walk(64'h03BC_DEF0_1234_5FFF, 1'b1, 5, 1'b0, "R5 bypass permitted", 1'b0);
        walk(64'h0800_0000_0000_1000, 1'b0, 5, 1'b0, "R5 bypass denied", 1'b0);
        walk(64'h1000_0000_0000_0000, 1'b0, 3, 1'b0, "R2 bad region", 1'b0);
        walk(64'h0000_0000_FFFF_1234, 1'b1, 3, 1'b1, "R3 message window enabled", 1'b0);
        walk(64'h0000_0000_FFFF_1234, 1'b1, 3, 1'b0, "R3 message window disabled", 1'b0);
        walk(a_rd, 1'b0, 6, 1'b0, "R6 depth five rejected", 1'b0);
        walk(a_rd, 1'b0, 8, 1'b0, "R6 depth four walked", 1'b0);
        walk(e_addr, 1'b0, 3, 1'b0, "R9 zero indirect entry", 1'b0);
        walk(d_addr, 1'b0, 3, 1'b0, "R12 memory error", 1'b0);
        walk(b_addr, 1'b0, 3, 1'b0, "R13 request during walk ignored", 1'b1);

        repeat (5) @(negedge clk);
        chk(exp_q.size() == 0, "R13 all results seen", 64'(exp_q.size()), 64'd0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule